// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable behavioural model of a single-port synchronous SRAM with byte lanes. Every control input except the output enable is sampled on the rising clock edge. An access starts when one of two active-low address strobes (a host strobe and a controller strobe) loads a new address. While the chip-select qualification is met, the address is captured and its two low bits seed a 2-bit burst position. Later cycles without a load continue the burst, and an active-low advance input steps the position.

Each accepted cycle is either a write or a read. A global write stores every lane. A byte write stores only the selected lanes. A read delivers its word one cycle later through a registered output stage. The output is gated by an asynchronous active-low enable and is shown as a zero data bus with a low valid flag. The output is held off for the first read that follows a deselected state. A sleep input freezes the block.

Top module: `sync_burst_sram`

## Requirements
- R1: On a rising edge with no sleep, where a load is taken (host strobe low with cs0_ni low, or controller strobe low) and all three chip selects are active (cs0_ni=0, cs1_i=1, cs2_ni=0), the cycle accesses addr_i, and addr_i[1:0] becomes the burst position.
- R2: When both strobes are low with the chip selects active, one load takes place at addr_i, and the cycle is a single access of the type the write controls decode.
- R3: The host strobe is ignored while cs0_ni is high. With the controller strobe high, that edge behaves as a burst continuation. With the controller strobe also low, it is a load that deselects.
- R4: Chip selects are examined only on a load edge. A load with any chip select inactive deselects the block, so later edges make no access until a selecting load. Chip select values on continuation edges have no effect.
- R5: On a continuation edge, a low burst_adv_ni steps the position by one modulo 4 from the loaded value, and that edge accesses the new position. A high burst_adv_ni accesses the same position again. The upper address bits stay at the loaded value.
- R6: A low wr_all_ni on an accessing edge writes all four byte lanes with wdata_i, whatever wr_byte_ni and lane_ni hold.
- R7: With wr_all_ni high and wr_byte_ni low, lane i (data bits [8i+7:8i]) is written only where lane_ni[i] is 0. If no lane is selected, or if wr_byte_ni is high, the access is a read.
- R8: Read data appears on rdata_o in the cycle after the issuing edge. rvalid_o is 1 only while out_en_ni is low, and it follows out_en_ni without waiting for a clock. rdata_o is zero whenever rvalid_o is 0.
- R9: The first read issued by a load while the block is deselected (reset included) keeps rvalid_o low in its output cycle, whatever out_en_ni is. The read after it is delivered normally.
- R10: While sleep_i is high, an edge loads nothing, writes nothing and does not move the burst position. rvalid_o is low in the following cycle.
- R11: During and directly after reset, rvalid_o is 0, rdata_o is 0, and the block is deselected.
- R12: A read of a location issued on the edge right after a write to it returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 4*LANE_W | Write data, captured with the write command |
| host_strb_ni | input | 1 | Host address strobe, active low, has priority |
| ctl_strb_ni | input | 1 | Controller address strobe, active low |
| burst_adv_ni | input | 1 | Burst advance, active low |
| cs0_ni | input | 1 | Chip select, active low, also qualifies the host strobe |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| wr_all_ni | input | 1 | Global write, active low |
| wr_byte_ni | input | 1 | Byte-write enable, active low |
| lane_ni | input | LANES | Per-lane write selects, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, active high, blocks accesses |
| rdata_o | output | 4*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Data output driven (not tri-stated) |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the control inputs are stable around the rising edge, because out_en_ni is the only input allowed to move within a cycle. The bench changes every synchronous input on the falling edge. It moves out_en_ni only between two samples taken inside one cycle. It reads only locations that it has written earlier, so no check depends on memory contents left undefined after reset.

// File: rtl/sram_burst_pkg.sv
`timescale 1ns/1ps
package sram_burst_pkg;
  localparam int unsigned BURST_W = 2;
  typedef enum logic [1:0] {ACC_IDLE = 2'd0, ACC_READ = 2'd1, ACC_WRITE = 2'd2} acc_e;
endpackage

// File: rtl/sram_addr_ctrl.sv
`timescale 1ns/1ps
module sram_addr_ctrl
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              host_strb_ni,
  input  logic              ctl_strb_ni,
  input  logic              burst_adv_ni,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [LANES-1:0]  lane_ni,
  input  logic              sleep_i,
  output acc_e              acc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic              first_o
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  logic               active_q, active_d;
  logic [UP_W-1:0]    base_q, base_d;
  logic [BURST_W-1:0] pos_q, pos_d;
  logic               host_hit, ctl_hit, load, selected;
  logic [LANES-1:0]   be;

  // host strobe outranks controller strobe; it needs cs0 low to count
  assign host_hit = !host_strb_ni && !cs0_ni;
  assign ctl_hit  = !ctl_strb_ni;
  assign load     = !sleep_i && (host_hit || ctl_hit);
  assign selected = !cs0_ni && cs1_i && !cs2_ni;

  always_comb begin
    if (!wr_all_ni)       be = '1;
    else if (!wr_byte_ni) be = ~lane_ni;
    else                  be = '0;
  end

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    pos_d    = pos_q;
    acc_o    = ACC_IDLE;
    addr_o   = {base_q, pos_q};
    be_o     = '0;
    first_o  = 1'b0;
    if (load) begin
      active_d = selected;
      if (selected) begin
        base_d  = addr_i[ADDR_W-1:BURST_W];
        pos_d   = addr_i[BURST_W-1:0];
        addr_o  = addr_i;
        acc_o   = (|be) ? ACC_WRITE : ACC_READ;
        be_o    = be;
        first_o = !active_q;
      end
    end else if (!sleep_i && active_q) begin
      if (!burst_adv_ni) pos_d = BURST_W'(pos_q + 1'b1);
      addr_o = {base_q, pos_d};
      acc_o  = (|be) ? ACC_WRITE : ACC_READ;
      be_o   = be;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      pos_q    <= '0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      pos_q    <= pos_d;
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
`timescale 1ns/1ps
module sram_byte_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_read_stage.sv
`timescale 1ns/1ps
module sram_read_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              out_en_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              valid_q, mask_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mask_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= issue_i;
      mask_q  <= issue_i && first_i;
      if (issue_i) data_q <= data_i;
    end
  end

  // output enable acts without a clock; masked on first read after deselect
  assign rvalid_o = valid_q && !mask_q && !out_en_ni;
  assign rdata_o  = rvalid_o ? data_q : '0;
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    host_strb_ni,
  input  logic                    ctl_strb_ni,
  input  logic                    burst_adv_ni,
  input  logic                    cs0_ni,
  input  logic                    cs1_i,
  input  logic                    cs2_ni,
  input  logic                    wr_all_ni,
  input  logic                    wr_byte_ni,
  input  logic [LANES-1:0]        lane_ni,
  input  logic                    out_en_ni,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  acc_e              acc;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  byte_en;
  logic              first_rd;
  logic [DATA_W-1:0] arr_rdata;

  sram_addr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .host_strb_ni, .ctl_strb_ni, .burst_adv_ni,
    .cs0_ni, .cs1_i, .cs2_ni, .wr_all_ni, .wr_byte_ni, .lane_ni, .sleep_i,
    .acc_o(acc), .addr_o(eff_addr), .be_o(byte_en), .first_o(first_rd)
  );

  sram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(acc == ACC_WRITE), .addr_i(eff_addr), .be_i(byte_en),
    .wdata_i, .rdata_o(arr_rdata)
  );

  sram_read_stage #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .issue_i(acc == ACC_READ), .first_i(first_rd),
    .data_i(arr_rdata), .out_en_ni, .rdata_o, .rvalid_o
  );
endmodule

// File: rtl/sram_burst_checks.sv
`timescale 1ns/1ps
module sram_burst_checks
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              host_strb_ni,
  input logic              ctl_strb_ni,
  input logic              burst_adv_ni,
  input logic              cs0_ni,
  input logic              cs1_i,
  input logic              cs2_ni,
  input logic              wr_all_ni,
  input logic              wr_byte_ni,
  input logic [LANES-1:0]  lane_ni,
  input logic              out_en_ni,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input acc_e              acc,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [LANES-1:0]  byte_en
);
  logic sel_all, no_load;
  assign sel_all = !cs0_ni && cs1_i && !cs2_ni;
  assign no_load = ctl_strb_ni && (host_strb_ni || cs0_ni);

  assert_both_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_strb_ni && !ctl_strb_ni && sel_all && !sleep_i) |-> (acc != ACC_IDLE && eff_addr == addr_i));

  assert_host_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_strb_ni && cs0_ni && !ctl_strb_ni && !sleep_i) |-> acc == ACC_IDLE);

  assert_burst_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc) != ACC_IDLE && acc != ACC_IDLE && no_load && !burst_adv_ni) |->
    (eff_addr[1:0] == 2'($past(eff_addr[1:0]) + 2'd1) && eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

  assert_global_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_all_ni && acc != ACC_IDLE) |-> (acc == ACC_WRITE && &byte_en));

  assert_lane_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_all_ni && !wr_byte_ni && acc != ACC_IDLE) |-> byte_en == ~lane_ni);

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !rvalid_o);

  assert_zero_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);

  assert_pipe_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(acc) == ACC_READ);

  assert_sleep_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> acc == ACC_IDLE);

  assert_sleep_output_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rvalid_o);
endmodule

bind sync_burst_sram sram_burst_checks #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .host_strb_ni(host_strb_ni),
  .ctl_strb_ni(ctl_strb_ni), .burst_adv_ni(burst_adv_ni), .cs0_ni(cs0_ni), .cs1_i(cs1_i),
  .cs2_ni(cs2_ni), .wr_all_ni(wr_all_ni), .wr_byte_ni(wr_byte_ni), .lane_ni(lane_ni),
  .out_en_ni(out_en_ni), .sleep_i(sleep_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
  .acc(acc), .eff_addr(eff_addr), .byte_en(byte_en)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 0, rst_ni = 0;
  logic [AW-1:0] addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic host_strb_ni, ctl_strb_ni, burst_adv_ni, cs0_ni, cs1_i, cs2_ni;
  logic wr_all_ni, wr_byte_ni, out_en_ni, sleep_i, rvalid_o;
  logic [3:0] lane_ni;
  logic [31:0] mem_m [DEPTH];
  int n_cmp = 0, n_mis = 0;

  always #10 clk_i = ~clk_i;

  sync_burst_sram dut (.*);

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'(a) * 32'h01030507) ^ (32'(salt) * 32'h9E3779B1) ^ 32'hA5C30F96;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_data(input string req, input logic [31:0] exp);
    chk(rvalid_o === 1'b1 && rdata_o === exp, req, {rdata_o[31:1], rvalid_o}, {exp[31:1], 1'b1});
    if (rvalid_o === 1'b1 && rdata_o !== exp) $display("  data act=%h exp=%h", rdata_o, exp);
  endtask

  task automatic chk_off(input string req);
    chk(rvalid_o === 1'b0 && rdata_o === '0, req, {rdata_o[31:1], rvalid_o}, 32'h0);
  endtask

  task automatic idle();
    host_strb_ni = 1; ctl_strb_ni = 1; burst_adv_ni = 1;
    cs0_ni = 0; cs1_i = 1; cs2_ni = 0;
    wr_all_ni = 1; wr_byte_ni = 1; lane_ni = '1; sleep_i = 0; out_en_ni = 0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic load_rd(input int a, input logic use_ctl);
    idle(); addr_i = AW'(a);
    if (use_ctl) ctl_strb_ni = 0; else host_strb_ni = 0;
    tick();
  endtask

  task automatic load_wr(input int a, input logic [31:0] d);
    idle(); addr_i = AW'(a); ctl_strb_ni = 0; wr_all_ni = 0; wdata_i = d;
    tick();
    mem_m[a] = d;
  endtask

  initial begin
    #(20 * 150000);
    n_mis++;
    $display("FAIL R11 watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    idle(); addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    chk_off("R11 in reset");
    rst_ni = 1;
    @(negedge clk_i);
    chk_off("R11 after reset");

    // fill every word with a global write (R6)
    for (int a = 0; a < DEPTH; a++) load_wr(a, pat(a, 0));

    // pipelined read sweep through both strobes (R1, R8)
    for (int a = 0; a < DEPTH; a++) begin
      load_rd(a, a[0]);
      chk_data("R1 read sweep", mem_m[a]);
    end

    // burst order from every start position, with hold and wrap (R5)
    for (int u = 0; u < 3; u++) begin
      for (int b = 0; b < 4; b++) begin
        int up = (u == 0) ? 0 : (u == 1) ? 5 : 15;
        load_rd(up * 4 + b, 1'b0);
        chk_data("R1 burst start", mem_m[up * 4 + b]);
        for (int k = 1; k < 4; k++) begin
          idle(); burst_adv_ni = 0; tick();
          chk_data("R5 burst step", mem_m[up * 4 + (b + k) % 4]);
        end
        idle(); tick();
        chk_data("R5 burst hold", mem_m[up * 4 + (b + 3) % 4]);
        idle(); burst_adv_ni = 0; tick();
        chk_data("R5 burst wrap", mem_m[up * 4 + b]);
      end
    end

    // byte-lane writes over all select patterns (R7)
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d = pat(m, 1);
      idle(); addr_i = AW'(10); ctl_strb_ni = 0; wr_byte_ni = 0; lane_ni = 4'(m); wdata_i = d;
      tick();
      for (int l = 0; l < 4; l++) if (!m[l]) mem_m[10][l*8 +: 8] = d[l*8 +: 8];
      load_rd(10, 1'b1);
      chk_data("R7 lane merge", mem_m[10]);
    end
    // byte-write enable high: no write, access becomes a read (R7)
    idle(); addr_i = AW'(11); ctl_strb_ni = 0; lane_ni = 4'h0; wdata_i = 32'hDEADBEEF; tick();
    chk_data("R7 no byte enable reads", mem_m[11]);

    // global write overrides lane selects (R6)
    idle(); addr_i = AW'(12); ctl_strb_ni = 0; wr_all_ni = 0; wr_byte_ni = 0; lane_ni = 4'hF;
    wdata_i = pat(12, 5); tick(); mem_m[12] = pat(12, 5);
    idle(); addr_i = AW'(13); ctl_strb_ni = 0; wr_all_ni = 0; lane_ni = 4'h5;
    wdata_i = pat(13, 5); tick(); mem_m[13] = pat(13, 5);
    load_rd(12, 1'b0); chk_data("R6 override with lanes off", mem_m[12]);
    load_rd(13, 1'b0); chk_data("R6 override byte enable high", mem_m[13]);

    // read right after write (R12)
    load_wr(20, pat(20, 7));
    load_rd(20, 1'b0);
    chk_data("R12 read after write", pat(20, 7));

    // burst write then burst read (R5, R6)
    load_wr(14, pat(14, 2));
    for (int k = 1; k < 4; k++) begin
      idle(); burst_adv_ni = 0; wr_all_ni = 0; wdata_i = pat(k, 3); tick();
      mem_m[12 + (2 + k) % 4] = pat(k, 3);
    end
    load_rd(14, 1'b0); chk_data("R5 write burst readback", mem_m[14]);
    for (int k = 1; k < 4; k++) begin
      idle(); burst_adv_ni = 0; tick();
      chk_data("R5 write burst readback", mem_m[12 + (2 + k) % 4]);
    end

    // asynchronous output enable (R8)
    load_rd(7, 1'b0);
    out_en_ni = 1; #1; chk_off("R8 oe high");
    out_en_ni = 0; #1; chk_data("R8 oe low same cycle", mem_m[7]);

    // host strobe ignored with cs0 high: continuation (R3)
    load_rd(16, 1'b1); chk_data("R1 start", mem_m[16]);
    idle(); host_strb_ni = 0; cs0_ni = 1; burst_adv_ni = 0; addr_i = AW'(50); tick();
    chk_data("R3 host ignored continues burst", mem_m[17]);
    // both strobes with cs0 high: controller load that deselects (R3)
    idle(); host_strb_ni = 0; ctl_strb_ni = 0; cs0_ni = 1; addr_i = AW'(50); tick();
    chk_off("R3 deselecting load");
    idle(); burst_adv_ni = 0; tick();
    chk_off("R4 deselected no access");
    idle(); wr_all_ni = 0; wdata_i = 32'h0BADF00D; tick();
    chk_off("R4 deselected no write");

    // first read after deselect is masked (R9)
    load_rd(30, 1'b0); chk_off("R9 first read masked");
    idle(); burst_adv_ni = 0; tick();
    chk_data("R9 next read delivered", mem_m[31]);
    for (int a = 16; a < 20; a++) begin
      load_rd(a, 1'b1); chk_data("R4 no write while deselected", mem_m[a]);
    end
    // deselect via cs2, then write-first load, then read (R9, R12)
    idle(); ctl_strb_ni = 0; cs2_ni = 1; addr_i = AW'(40); tick();
    chk_off("R4 deselect by cs2");
    load_wr(40, pat(40, 9));
    load_rd(40, 1'b0);
    chk_data("R9 write-first load not masked", pat(40, 9));

    // chip selects ignored on continuation (R4)
    load_rd(24, 1'b0); chk_data("R1 start", mem_m[24]);
    idle(); burst_adv_ni = 0; cs0_ni = 1; cs1_i = 0; cs2_ni = 1; tick();
    chk_data("R4 selects ignored in burst", mem_m[25]);

    // both strobes, selected (R2)
    idle(); host_strb_ni = 0; ctl_strb_ni = 0; addr_i = AW'(9); tick();
    chk_data("R2 both strobes read", mem_m[9]);
    idle(); host_strb_ni = 0; ctl_strb_ni = 0; addr_i = AW'(9); wr_all_ni = 0;
    wdata_i = pat(9, 11); tick(); mem_m[9] = pat(9, 11);
    chk_off("R2 single write no output");
    load_rd(9, 1'b1); chk_data("R2 write landed", mem_m[9]);

    // sleep blocks load, write and advance (R10)
    load_rd(29, 1'b0); chk_data("R1 start", mem_m[29]);
    idle(); sleep_i = 1; burst_adv_ni = 0; wr_all_ni = 0; ctl_strb_ni = 0;
    addr_i = AW'(0); wdata_i = 32'h12345678; tick();
    chk_off("R10 no output after sleep");
    idle(); burst_adv_ni = 0; tick();
    chk_data("R10 burst position kept", mem_m[30]);
    load_rd(0, 1'b0); chk_data("R10 no write during sleep", mem_m[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule